// File: doc/BRIEF.md
# Bootloader Command Responder

This block sits on the device side of a serial in-system programming link, between a packet receiver that has already checked framing and checksums and a packet transmitter that wraps payloads into frames. The request payload arrives as a byte stream. The first byte selects the command. When the command is complete, the block builds the acknowledge payload and streams it out. It also moves a small session phase forward and raises one-cycle action strobes for the surrounding logic: a baud-rate trial or switch, an erase, an option update, or a device reset request.

Write commands are not buffered. Each data byte goes straight to an abstract flash port with its own address, one cycle after the byte is accepted. An 8-bit running sum of the block is kept for the acknowledge. Most acknowledges are derived from the request itself. A baud acknowledge echoes the request with a pad byte appended. A switch acknowledge also rewrites its leading byte.

Top module: `bl_cmd_responder`

## Requirements
- R1: A request whose first byte is 0x8F, that is 5 to 8 bytes long, and whose byte 4 equals (2 × (256 − byte 2)) mod 256 is acknowledged with every request byte unchanged, followed by one pad byte 0x00. After the last acknowledge byte is taken, `baud_test_o` pulses for one cycle while `baud_brt_o` shows byte 2.
- R2: A request of type 0x8E that passes the same length and check rules is acknowledged like R1, except that byte 0 of the acknowledge is 0x84. It moves the phase from 0 to 1 and pulses `baud_switch_o` after the acknowledge.
- R3: A baud request (0x8F or 0x8E) with a wrong check byte or a length outside 5..8 produces no acknowledge, no strobe and no phase change.
- R4: A write request has type 0x00, address in bytes 3..4 (big-endian), size in bytes 5..6 (big-endian) equal to 0x0080, and 128 data bytes from byte 7 on. In phase 2, the data byte at offset k is written to address+k one cycle after it is accepted. The acknowledge is 0x00 followed by the 8-bit sum of the data bytes.
- R5: A write request whose size field is not 0x0080, whose total length is not 135, or that arrives outside phase 2 gets no acknowledge and produces a one-cycle `err_o` pulse. If the size is wrong or the phase is wrong, no flash write is issued.
- R6: A request of type 0x84 that is at least 7 bytes long is acknowledged with the single byte 0x00. It moves the phase to 2. After the acknowledge it pulses `erase_o`, with `erase_pages_o` equal to the 256-byte count in byte 3 rounded up to whole 512-byte pages.
- R7: A request of type 0x69 is acknowledged with the single byte 0x8D and moves the phase to 3.
- R8: A request of type 0x8D that is exactly 21 bytes long is acknowledged with the single byte 0x50. After the acknowledge it pulses `opt_o`. `opt_cfg_o` carries bytes 1..16, with byte 1 in the top bits. `opt_clk_o` carries bytes 17..20 as a big-endian value.
- R9: A request of type 0x82 produces no acknowledge. It sets the phase to 0 and pulses `reset_req_o` two cycles after its last byte is accepted.
- R10: A request with any other type byte produces no acknowledge, no strobe, no error and no phase change.
- R11: `req_ready_o` is low from the cycle after a request's last byte until the cycle after the final strobe slot. Acknowledge bytes are held stable while `rsp_ready_i` is low.
- R12: After reset the phase is 0, `req_ready_o` is high and no acknowledge is pending. Phase codes are: 0 unsynchronised, 1 link switched, 2 erased, 3 programming finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request payload byte valid |
| req_data_i | input | 8 | Request payload byte |
| req_last_i | input | 1 | Marks the last byte of a request |
| req_ready_o | output | 1 | Request byte accepted when high |
| rsp_valid_o | output | 1 | Acknowledge byte valid |
| rsp_data_o | output | 8 | Acknowledge byte |
| rsp_last_o | output | 1 | Marks the last acknowledge byte |
| rsp_ready_i | input | 1 | Transmitter takes the acknowledge byte |
| fl_we_o | output | 1 | Flash byte write strobe |
| fl_addr_o | output | 16 | Flash byte address |
| fl_wdata_o | output | 8 | Flash byte data |
| baud_test_o | output | 1 | Baud trial strobe |
| baud_switch_o | output | 1 | Baud switch strobe |
| baud_brt_o | output | 8 | Baud timer value for the strobes |
| erase_o | output | 1 | Erase strobe |
| erase_pages_o | output | 8 | Number of 512-byte pages to erase |
| opt_o | output | 1 | Option update strobe |
| opt_cfg_o | output | 128 | Sixteen configuration bytes |
| opt_clk_o | output | 32 | Measured clock in Hz |
| reset_req_o | output | 1 | Device reset request |
| err_o | output | 1 | Malformed or misplaced write |
| phase_o | output | 2 | Session phase |

## Verification
Most internal faults show up within the same command. A wrong byte counter or header capture corrupts the echoed acknowledge or the flash address as soon as that byte is streamed. A lost type or size flag turns a write acknowledge into an error pulse two cycles after the last request byte. A wrong phase register is slower to show: it stays hidden until a later command is gated by it. For that reason, the bench reads `phase_o` after every command, and it sends a write both before and after the erase.

// File: rtl/bl_cmd_pkg.sv
package bl_cmd_pkg;
  typedef logic [7:0] byte_t;

  typedef enum logic [1:0] {
    PH_SYNC     = 2'd0,
    PH_LINKED   = 2'd1,
    PH_ERASED   = 2'd2,
    PH_FINISHED = 2'd3
  } phase_e;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_BAUD_TEST,
    ACT_BAUD_SWITCH,
    ACT_ERASE,
    ACT_OPTIONS,
    ACT_RESET
  } act_e;

  localparam byte_t TY_WRITE       = 8'h00;
  localparam byte_t TY_BAUD_TEST   = 8'h8F;
  localparam byte_t TY_BAUD_SWITCH = 8'h8E;
  localparam byte_t TY_ERASE       = 8'h84;
  localparam byte_t TY_FINISH      = 8'h69;
  localparam byte_t TY_OPTIONS     = 8'h8D;
  localparam byte_t TY_RESET       = 8'h82;

  localparam byte_t ACK_OK     = 8'h00;
  localparam byte_t ACK_FINISH = 8'h8D;
  localparam byte_t ACK_OPT    = 8'h50;
  localparam byte_t SWITCH_TAG = 8'h84;
  localparam byte_t PAD_BYTE   = 8'h00;

  // (2 * (256 - v)) mod 256
  function automatic byte_t baud_chk(byte_t v);
    byte_t n;
    n = 8'd0 - v;
    return {n[6:0], 1'b0};
  endfunction
endpackage

// File: rtl/bl_rx_parse.sv
module bl_rx_parse
  import bl_cmd_pkg::*;
#(
  parameter int HDR_BYTES = 21,
  parameter int BLK_BYTES = 128,
  parameter int CNT_W     = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  byte_t            req_data_i,
  input  logic             req_last_i,
  input  logic             accept_i,
  input  logic             wr_allow_i,
  output logic             done_o,
  output logic [CNT_W-1:0] len_o,
  output byte_t            hdr_o [HDR_BYTES],
  output byte_t            sum_o,
  output logic             wr_good_o,
  output logic             fl_we_o,
  output logic [15:0]      fl_addr_o,
  output byte_t            fl_wdata_o
);
  localparam int               DATA_OFS = 7;
  localparam logic [CNT_W-1:0] OFS_C    = CNT_W'(DATA_OFS);
  localparam logic [CNT_W-1:0] END_C    = CNT_W'(DATA_OFS + BLK_BYTES);
  localparam logic [15:0]      BLK_SIZE = 16'(BLK_BYTES);

  logic             acc;
  logic [CNT_W-1:0] cnt_q, len_q;
  byte_t            hdr_q [HDR_BYTES];
  byte_t            sum_q, fl_data_q;
  logic             done_q, wr_ty_q, sz_hi_q, sz_ok_q, fl_we_q;
  logic [15:0]      fl_addr_q;
  logic             in_blk;
  logic [15:0]      blk_ofs;

  assign acc     = req_valid_i & accept_i;
  assign in_blk  = (cnt_q >= OFS_C) && (cnt_q < END_C);
  assign blk_ofs = 16'(cnt_q - OFS_C);

  for (genvar g = 0; g < HDR_BYTES; g++) begin : g_hdr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hdr_q[g] <= '0;
      else if (acc && cnt_q == CNT_W'(g)) hdr_q[g] <= req_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      len_q     <= '0;
      done_q    <= 1'b0;
      wr_ty_q   <= 1'b0;
      sz_hi_q   <= 1'b0;
      sz_ok_q   <= 1'b0;
      sum_q     <= '0;
      fl_we_q   <= 1'b0;
      fl_addr_q <= '0;
      fl_data_q <= '0;
    end else begin
      done_q  <= acc & req_last_i;
      fl_we_q <= 1'b0;
      if (acc) begin
        if (req_last_i) begin
          cnt_q <= '0;
          len_q <= cnt_q + 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        if (cnt_q == '0) begin
          wr_ty_q <= (req_data_i == TY_WRITE);
          sz_hi_q <= 1'b0;
          sz_ok_q <= 1'b0;
          sum_q   <= '0;
        end
        if (cnt_q == CNT_W'(5)) sz_hi_q <= (req_data_i == BLK_SIZE[15:8]);
        if (cnt_q == CNT_W'(6)) sz_ok_q <= sz_hi_q && (req_data_i == BLK_SIZE[7:0]);
        if (cnt_q >= OFS_C) sum_q <= sum_q + req_data_i;
        // stream data straight to flash, no block buffer
        if (wr_ty_q && sz_ok_q && wr_allow_i && in_blk) begin
          fl_we_q   <= 1'b1;
          fl_addr_q <= {hdr_q[3], hdr_q[4]} + blk_ofs;
          fl_data_q <= req_data_i;
        end
      end
    end
  end

  assign done_o     = done_q;
  assign len_o      = len_q;
  assign hdr_o      = hdr_q;
  assign sum_o      = sum_q;
  assign wr_good_o  = wr_ty_q & sz_ok_q & (len_q == END_C);
  assign fl_we_o    = fl_we_q;
  assign fl_addr_o  = fl_addr_q;
  assign fl_wdata_o = fl_data_q;
endmodule

// File: rtl/bl_cmd_decode.sv
module bl_cmd_decode
  import bl_cmd_pkg::*;
#(
  parameter int BAUD_MAX = 8,
  parameter int OPT_LEN  = 21,
  parameter int CNT_W    = 16,
  localparam int RSP_MAX = BAUD_MAX + 1,
  localparam int LW      = $clog2(RSP_MAX + 1)
) (
  input  byte_t            echo_i [BAUD_MAX],
  input  logic [CNT_W-1:0] len_i,
  input  byte_t            sum_i,
  input  logic             wr_good_i,
  input  phase_e           phase_i,
  output logic [LW-1:0]    rsp_len_o,
  output byte_t            rsp_buf_o [RSP_MAX],
  output act_e             act_o,
  output phase_e           phase_nxt_o,
  output logic             err_o
);
  logic baud_ok;

  assign baud_ok = (len_i >= CNT_W'(5)) && (len_i <= CNT_W'(BAUD_MAX)) &&
                   (echo_i[4] == baud_chk(echo_i[2]));

  always_comb begin
    rsp_len_o   = '0;
    act_o       = ACT_NONE;
    phase_nxt_o = phase_i;
    err_o       = 1'b0;
    for (int i = 0; i < RSP_MAX; i++) rsp_buf_o[i] = '0;

    unique case (echo_i[0])
      TY_BAUD_TEST, TY_BAUD_SWITCH: begin
        if (baud_ok) begin
          for (int i = 0; i < BAUD_MAX; i++)
            if (CNT_W'(i) < len_i) rsp_buf_o[i] = echo_i[i];
          for (int i = 0; i < RSP_MAX; i++)
            if (CNT_W'(i) == len_i) rsp_buf_o[i] = PAD_BYTE;
          rsp_len_o = LW'(len_i + 1'b1);
          if (echo_i[0] == TY_BAUD_SWITCH) begin
            rsp_buf_o[0] = SWITCH_TAG;
            act_o        = ACT_BAUD_SWITCH;
            if (phase_i == PH_SYNC) phase_nxt_o = PH_LINKED;
          end else begin
            act_o = ACT_BAUD_TEST;
          end
        end
      end
      TY_WRITE: begin
        if (wr_good_i && phase_i == PH_ERASED) begin
          rsp_len_o    = LW'(2);
          rsp_buf_o[0] = ACK_OK;
          rsp_buf_o[1] = sum_i;
        end else begin
          err_o = 1'b1;
        end
      end
      TY_ERASE: begin
        if (len_i >= CNT_W'(7)) begin
          rsp_len_o    = LW'(1);
          rsp_buf_o[0] = ACK_OK;
          act_o        = ACT_ERASE;
          phase_nxt_o  = PH_ERASED;
        end
      end
      TY_FINISH: begin
        rsp_len_o    = LW'(1);
        rsp_buf_o[0] = ACK_FINISH;
        phase_nxt_o  = PH_FINISHED;
      end
      TY_OPTIONS: begin
        if (len_i == CNT_W'(OPT_LEN)) begin
          rsp_len_o    = LW'(1);
          rsp_buf_o[0] = ACK_OPT;
          act_o        = ACT_OPTIONS;
        end
      end
      TY_RESET: begin
        act_o       = ACT_RESET;
        phase_nxt_o = PH_SYNC;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bl_rsp_gen.sv
module bl_rsp_gen
  import bl_cmd_pkg::*;
#(
  parameter int RSP_MAX = 9,
  localparam int LW     = $clog2(RSP_MAX + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [LW-1:0] len_i,
  input  byte_t         buf_i [RSP_MAX],
  input  logic          rsp_ready_i,
  output logic          rsp_valid_o,
  output byte_t         rsp_data_o,
  output logic          rsp_last_o,
  output logic          busy_o,
  output logic          fin_o
);
  byte_t         buf_q [RSP_MAX];
  logic [LW-1:0] len_q, idx_q;
  logic          act_q, fin_q;
  logic          at_end;

  assign at_end = (idx_q == len_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < RSP_MAX; i++) buf_q[i] <= '0;
      len_q <= '0;
      idx_q <= '0;
      act_q <= 1'b0;
      fin_q <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (load_i) begin
        buf_q <= buf_i;
        len_q <= len_i;
        idx_q <= '0;
        act_q <= (len_i != '0);
        fin_q <= (len_i == '0);
      end else if (act_q && rsp_ready_i) begin
        if (at_end) begin
          act_q <= 1'b0;
          fin_q <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign rsp_valid_o = act_q;
  assign rsp_data_o  = buf_q[idx_q];
  assign rsp_last_o  = act_q & at_end;
  assign busy_o      = act_q | fin_q;
  assign fin_o       = fin_q;
endmodule

// File: rtl/bl_cmd_responder.sv
module bl_cmd_responder
  import bl_cmd_pkg::*;
#(
  parameter int BAUD_MAX  = 8,
  parameter int BLK_BYTES = 128,
  parameter int CNT_W     = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [7:0]    req_data_i,
  input  logic          req_last_i,
  output logic          req_ready_o,
  output logic          rsp_valid_o,
  output logic [7:0]    rsp_data_o,
  output logic          rsp_last_o,
  input  logic          rsp_ready_i,
  output logic          fl_we_o,
  output logic [15:0]   fl_addr_o,
  output logic [7:0]    fl_wdata_o,
  output logic          baud_test_o,
  output logic          baud_switch_o,
  output logic [7:0]    baud_brt_o,
  output logic          erase_o,
  output logic [7:0]    erase_pages_o,
  output logic          opt_o,
  output logic [127:0]  opt_cfg_o,
  output logic [31:0]   opt_clk_o,
  output logic          reset_req_o,
  output logic          err_o,
  output logic [1:0]    phase_o
);
  localparam int CFG_BYTES = 16;
  localparam int OPT_LEN   = 1 + CFG_BYTES + 4;
  localparam int HDR_BYTES = (OPT_LEN > BAUD_MAX) ? OPT_LEN : BAUD_MAX;
  localparam int RSP_MAX   = BAUD_MAX + 1;
  localparam int LW        = $clog2(RSP_MAX + 1);

  logic             done, wr_good, gen_busy, fin, accept, dec_err;
  logic [CNT_W-1:0] len;
  byte_t            hdr [HDR_BYTES];
  byte_t            echo [BAUD_MAX];
  byte_t            sum;
  logic [LW-1:0]    rsp_len;
  byte_t            rsp_buf [RSP_MAX];
  act_e             act_d, act_q;
  phase_e           phase_d, phase_q;
  logic             err_q;
  logic [8:0]       pages_rnd;

  assign accept      = ~(done | gen_busy);
  assign req_ready_o = accept;

  bl_rx_parse #(
    .HDR_BYTES(HDR_BYTES),
    .BLK_BYTES(BLK_BYTES),
    .CNT_W    (CNT_W)
  ) u_parse (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .req_data_i (req_data_i),
    .req_last_i (req_last_i),
    .accept_i   (accept),
    .wr_allow_i (phase_q == PH_ERASED),
    .done_o     (done),
    .len_o      (len),
    .hdr_o      (hdr),
    .sum_o      (sum),
    .wr_good_o  (wr_good),
    .fl_we_o    (fl_we_o),
    .fl_addr_o  (fl_addr_o),
    .fl_wdata_o (fl_wdata_o)
  );

  for (genvar g = 0; g < BAUD_MAX; g++) begin : g_echo
    assign echo[g] = hdr[g];
  end

  bl_cmd_decode #(
    .BAUD_MAX(BAUD_MAX),
    .OPT_LEN (OPT_LEN),
    .CNT_W   (CNT_W)
  ) u_dec (
    .echo_i     (echo),
    .len_i      (len),
    .sum_i      (sum),
    .wr_good_i  (wr_good),
    .phase_i    (phase_q),
    .rsp_len_o  (rsp_len),
    .rsp_buf_o  (rsp_buf),
    .act_o      (act_d),
    .phase_nxt_o(phase_d),
    .err_o      (dec_err)
  );

  bl_rsp_gen #(
    .RSP_MAX(RSP_MAX)
  ) u_gen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (done),
    .len_i      (rsp_len),
    .buf_i      (rsp_buf),
    .rsp_ready_i(rsp_ready_i),
    .rsp_valid_o(rsp_valid_o),
    .rsp_data_o (rsp_data_o),
    .rsp_last_o (rsp_last_o),
    .busy_o     (gen_busy),
    .fin_o      (fin)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_SYNC;
      act_q   <= ACT_NONE;
      err_q   <= 1'b0;
    end else begin
      err_q <= done & dec_err;
      if (done) begin
        phase_q <= phase_d;
        act_q   <= act_d;
      end
    end
  end

  // header stays frozen until fin: ready is low in between
  assign pages_rnd     = {1'b0, hdr[3]} + 9'd1;
  assign erase_pages_o = pages_rnd[8:1];
  assign baud_brt_o    = hdr[2];
  for (genvar g = 0; g < CFG_BYTES; g++) begin : g_cfg
    assign opt_cfg_o[8*(CFG_BYTES-g)-1 -: 8] = hdr[1+g];
  end
  assign opt_clk_o = {hdr[CFG_BYTES+1], hdr[CFG_BYTES+2], hdr[CFG_BYTES+3], hdr[CFG_BYTES+4]};

  assign baud_test_o   = fin & (act_q == ACT_BAUD_TEST);
  assign baud_switch_o = fin & (act_q == ACT_BAUD_SWITCH);
  assign erase_o       = fin & (act_q == ACT_ERASE);
  assign opt_o         = fin & (act_q == ACT_OPTIONS);
  assign reset_req_o   = fin & (act_q == ACT_RESET);
  assign err_o         = err_q;
  assign phase_o       = phase_q;
endmodule

// File: rtl/bl_cmd_responder_chk.sv
module bl_cmd_responder_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_ready_o,
  input logic       rsp_valid_o,
  input logic [7:0] rsp_data_o,
  input logic       rsp_last_o,
  input logic       rsp_ready_i,
  input logic       fl_we_o,
  input logic       baud_test_o,
  input logic       baud_switch_o,
  input logic       erase_o,
  input logic       opt_o,
  input logic       reset_req_o,
  input logic       err_o,
  input logic [1:0] phase_o
);
  p_rsp_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_data_o) && $stable(rsp_last_o));

  p_no_req_during_rsp_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !req_ready_o);

  p_write_needs_erase_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_we_o |-> phase_o == 2'd2);

  p_single_strobe_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({baud_test_o, baud_switch_o, erase_o, opt_o, reset_req_o, err_o}));

  p_reset_to_sync_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_o |-> phase_o == 2'd0);

  p_switch_linked_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    baud_switch_o |-> phase_o != 2'd0);

  p_erase_phase_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_o |-> phase_o == 2'd2);

  p_phase_moves_on_cmd_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(phase_o) |-> $past(!req_ready_o));
endmodule

bind bl_cmd_responder bl_cmd_responder_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_ready_o  (req_ready_o),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_data_o   (rsp_data_o),
  .rsp_last_o   (rsp_last_o),
  .rsp_ready_i  (rsp_ready_i),
  .fl_we_o      (fl_we_o),
  .baud_test_o  (baud_test_o),
  .baud_switch_o(baud_switch_o),
  .erase_o      (erase_o),
  .opt_o        (opt_o),
  .reset_req_o  (reset_req_o),
  .err_o        (err_o),
  .phase_o      (phase_o)
);

// File: tb/tb_bl_cmd_responder.sv
`timescale 1ns/1ps
module tb_bl_cmd_responder;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_last = 1'b0, rsp_ready = 1'b1;
  logic [7:0] req_data = '0;
  logic req_ready, rsp_valid, rsp_last, fl_we;
  logic [7:0] rsp_data, fl_wdata, brt, pages;
  logic [15:0] fl_addr;
  logic b_test, b_sw, er, opt, rreq, err;
  logic [127:0] cfg;
  logic [31:0] clk_hz;
  logic [1:0] phase;

  always #2.5 clk = ~clk;

  bl_cmd_responder dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_data_i(req_data), .req_last_i(req_last), .req_ready_o(req_ready),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .rsp_last_o(rsp_last), .rsp_ready_i(rsp_ready),
    .fl_we_o(fl_we), .fl_addr_o(fl_addr), .fl_wdata_o(fl_wdata),
    .baud_test_o(b_test), .baud_switch_o(b_sw), .baud_brt_o(brt),
    .erase_o(er), .erase_pages_o(pages), .opt_o(opt), .opt_cfg_o(cfg), .opt_clk_o(clk_hz),
    .reset_req_o(rreq), .err_o(err), .phase_o(phase)
  );

  int tests = 0, fails = 0;
  int cyc = 0, last_cyc = 0, rreq_cyc = 0;
  int n_test = 0, n_sw = 0, n_er = 0, n_opt = 0, n_rst = 0, n_err = 0;
  logic [7:0] cap_brt = '0, cap_pages = '0;
  logic [127:0] cap_cfg = '0;
  logic [31:0] cap_clk = '0;
  logic [8:0]  exp_rsp [$];
  logic [23:0] exp_fl [$];
  logic bp_en = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    rsp_ready = bp_en ? lfsr[0] : 1'b1;
  end

  // monitor: scoreboard for acknowledge bytes and flash writes
  always @(negedge clk) if (rst_n) begin
    if (rsp_valid && rsp_ready) begin
      if (exp_rsp.size() == 0) chk("R10", "unexpected ack byte", {55'd0, rsp_last, rsp_data}, 64'h1ff);
      else begin
        logic [8:0] e;
        e = exp_rsp.pop_front();
        chk("R1", "ack {last,byte}", {55'd0, rsp_last, rsp_data}, {55'd0, e});
      end
    end
    if (fl_we) begin
      if (exp_fl.size() == 0) chk("R5", "unexpected flash write", {40'd0, fl_addr, fl_wdata}, 64'hffffff);
      else begin
        logic [23:0] f;
        f = exp_fl.pop_front();
        chk("R4", "flash {addr,data}", {40'd0, fl_addr, fl_wdata}, {40'd0, f});
      end
    end
    if (req_valid && req_ready && req_last) last_cyc = cyc;
    if (b_test) begin n_test++; cap_brt = brt; end
    if (b_sw)   begin n_sw++;   cap_brt = brt; end
    if (er)     begin n_er++;   cap_pages = pages; end
    if (opt)    begin n_opt++;  cap_cfg = cfg; cap_clk = clk_hz; end
    if (rreq)   begin n_rst++;  rreq_cyc = cyc; end
    if (err)    n_err++;
  end

  task automatic push_rsp(logic [7:0] b[$]);
    foreach (b[i]) exp_rsp.push_back({(i == b.size() - 1), b[i]});
  endtask

  task automatic send(logic [7:0] p[$], string req);
    foreach (p[i]) begin
      req_valid = 1'b1;
      req_data  = p[i];
      req_last  = (i == p.size() - 1);
      do @(negedge clk); while (!req_ready);
      @(posedge clk); #1;
    end
    req_valid = 1'b0;
    req_last  = 1'b0;
    @(negedge clk);
    chk(req, "ready low after last byte (R11)", {63'd0, req_ready}, 64'd0);
    for (int k = 0; k < 300 && (!req_ready || exp_rsp.size() != 0); k++) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(req, "ack bytes left", 64'(exp_rsp.size()), 64'd0);
    chk(req, "flash writes left", 64'(exp_fl.size()), 64'd0);
    exp_rsp.delete();
    exp_fl.delete();
    @(posedge clk); #1;
  endtask

  function automatic logic [7:0] bchk(logic [7:0] v);
    logic [7:0] n;
    n = 8'd0 - v;
    return {n[6:0], 1'b0};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got hang expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] p[$];
    logic [7:0] e[$];
    logic [7:0] s;
    logic [127:0] xcfg;
    int c0;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12", "phase after reset", 64'(phase), 64'd0);
    chk("R12", "ready after reset", 64'(req_ready), 64'd1);
    chk("R12", "no ack after reset", 64'(rsp_valid), 64'd0);
    @(posedge clk); #1;

    // R10 unknown type
    p = '{8'h55, 8'h01, 8'h02};
    send(p, "R10");
    chk("R10", "phase unchanged", 64'(phase), 64'd0);
    chk("R10", "no strobe", 64'(n_test + n_sw + n_er + n_opt + n_rst + n_err), 64'd0);

    // R5 write before erase: error, no writes
    p = '{8'h00, 8'h00, 8'h00, 8'h10, 8'h00, 8'h00, 8'h80};
    for (int i = 0; i < 128; i++) p.push_back(8'(i));
    send(p, "R5");
    chk("R5", "error pulse, wrong phase", 64'(n_err), 64'd1);

    // R1 baud trial
    p = '{8'h8F, 8'hC0, 8'hF4, 8'h3F, bchk(8'hF4), 8'hA0, 8'h8A};
    e = p; e.push_back(8'h00);
    push_rsp(e);
    send(p, "R1");
    chk("R1", "trial strobe count", 64'(n_test), 64'd1);
    chk("R1", "trial timer value", 64'(cap_brt), 64'hF4);
    chk("R1", "phase stays 0", 64'(phase), 64'd0);

    // R3 bad check byte
    p = '{8'h8F, 8'hC0, 8'hF4, 8'h3F, 8'h19, 8'hA0, 8'h8A};
    send(p, "R3");
    chk("R3", "no trial strobe", 64'(n_test), 64'd1);
    // R3 too short
    p = '{8'h8E, 8'hC0, 8'hF4, 8'h3F};
    send(p, "R3");
    chk("R3", "no switch strobe", 64'(n_sw), 64'd0);
    chk("R3", "phase unchanged", 64'(phase), 64'd0);

    // R2 switch, six bytes
    p = '{8'h8E, 8'hC0, 8'hD9, 8'h3F, bchk(8'hD9), 8'hA0};
    e = p; e[0] = 8'h84; e.push_back(8'h00);
    push_rsp(e);
    send(p, "R2");
    chk("R2", "switch strobe", 64'(n_sw), 64'd1);
    chk("R2", "switch timer value", 64'(cap_brt), 64'hD9);
    chk("R2", "phase linked", 64'(phase), 64'd1);

    // R6 erase with odd count
    p = '{8'h84, 8'hFF, 8'h00, 8'h03, 8'h00, 8'h00, 8'h40};
    for (int i = 0; i < 13; i++) p.push_back(8'h00);
    p.push_back(8'h80); p.push_back(8'h7F); p.push_back(8'h0E);
    e = '{8'h00};
    push_rsp(e);
    send(p, "R6");
    chk("R6", "erase strobe", 64'(n_er), 64'd1);
    chk("R6", "pages rounded up", 64'(cap_pages), 64'd2);
    chk("R6", "phase erased", 64'(phase), 64'd2);

    // R4 good write under backpressure
    p = '{8'h00, 8'h00, 8'h00, 8'h12, 8'hF0, 8'h00, 8'h80};
    s = '0;
    for (int i = 0; i < 128; i++) begin
      logic [7:0] d;
      d = 8'(i * 3 + 1);
      p.push_back(d);
      s += d;
      exp_fl.push_back({16'h12F0 + 16'(i), d});
    end
    e = '{8'h00, s};
    push_rsp(e);
    bp_en = 1'b1;
    send(p, "R4");
    bp_en = 1'b0;
    chk("R4", "no error", 64'(n_err), 64'd1);

    // R5 wrong size field
    p = '{8'h00, 8'h00, 8'h00, 8'h20, 8'h00, 8'h00, 8'h40};
    for (int i = 0; i < 64; i++) p.push_back(8'hAA);
    send(p, "R5");
    chk("R5", "error pulse, bad size", 64'(n_err), 64'd2);
    // R5 short block: bytes written, no ack, error
    p = '{8'h00, 8'h00, 8'h00, 8'h30, 8'h00, 8'h00, 8'h80};
    for (int i = 0; i < 4; i++) begin
      p.push_back(8'h5A);
      exp_fl.push_back({16'h3000 + 16'(i), 8'h5A});
    end
    send(p, "R5");
    chk("R5", "error pulse, short block", 64'(n_err), 64'd3);
    chk("R5", "phase kept", 64'(phase), 64'd2);

    // R7 finish
    p = '{8'h69, 8'h00, 8'h00, 8'h36, 8'h01, 8'hF1, 8'h2A};
    e = '{8'h8D};
    push_rsp(e);
    send(p, "R7");
    chk("R7", "phase finished", 64'(phase), 64'd3);

    // R8 options
    p = '{8'h8D};
    xcfg = '0;
    for (int i = 0; i < 16; i++) begin
      p.push_back(8'h10 + 8'(i));
      xcfg = {xcfg[119:0], 8'h10 + 8'(i)};
    end
    p.push_back(8'h00); p.push_back(8'hB7); p.push_back(8'h1B); p.push_back(8'h00);
    e = '{8'h50};
    push_rsp(e);
    send(p, "R8");
    chk("R8", "option strobe", 64'(n_opt), 64'd1);
    chk("R8", "cfg high", cap_cfg[127:64], xcfg[127:64]);
    chk("R8", "cfg low", cap_cfg[63:0], xcfg[63:0]);
    chk("R8", "clock", 64'(cap_clk), 64'h00B71B00);

    // R10 unknown type in finished phase
    p = '{8'h77};
    send(p, "R10");
    chk("R10", "phase unchanged", 64'(phase), 64'd3);

    // R9 reset
    c0 = n_rst;
    p = '{8'h82};
    send(p, "R9");
    chk("R9", "reset strobe", 64'(n_rst - c0), 64'd1);
    chk("R9", "reset timing", 64'(rreq_cyc - last_cyc), 64'd2);
    chk("R9", "phase sync", 64'(phase), 64'd0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule